// File: doc/BRIEF.md
# Write-Intent Predictor with Write-Aware Install Bypass

This block sits beside a DRAM-cache controller and makes two decisions for every cache miss: whether the missing line should be installed in the cache or bypassed, and whether an installed line should be marked dirty at install time. Marking it early lets the controller fold the dirty-bit update into the tag write of the install, and also set the per-line dirtiness bit kept next to the last-level SRAM line. Both decisions rest on a table of small saturating counters. The table is indexed by a signature folded from the program counter of the instruction that caused the miss.

The controller trains the table when a line is evicted. The training event carries the signature PC that installed the line, whether the line was actually written while resident, and whether it had been predicted dirty. The block keeps four saturating counters of the prediction-versus-actual outcomes, so the misclassification rate can be read out.

The install policy favours writes. Write misses and reads predicted to be written are always installed. Reads predicted clean are mostly bypassed, and a free-running pseudo-random sequence lets roughly one in ten of them install anyway.

Top module: `write_intent_predictor`

## Requirements
- R1: The table index is `pc[10:2] ^ pc[19:11]` (9 bits, 512 entries). Two PCs with the same index share one counter.
- R2: A miss presented with `miss_valid` high at a clock edge produces its decision on `dec_valid`, `dec_install` and `dec_dirty` at the next edge. When no miss is presented, all three outputs are 0.
- R3: A write miss (`miss_is_write`=1) is always installed (`dec_install`=1) and marked dirty (`dec_dirty`=1).
- R4: A read miss whose counter is at least 2 is predicted written. It is installed with `dec_dirty`=1.
- R5: A read miss whose counter is below 2 is bypassed (`dec_install`=0, `dec_dirty`=0) when the low 10 bits of the random register are below 922. Otherwise it is installed with `dec_dirty`=0.
- R6: The random register is 16 bits. It loads 16'hACE1 in reset and shifts left every cycle after reset, taking in bit15^bit13^bit12^bit10. A decision uses the value held before that cycle's shift.
- R7: A training event with `train_written`=1 increments the 2-bit counter at the train index, saturating at 3. With `train_written`=0 it decrements the counter, saturating at 0.
- R8: Reset sets every counter to 1 (weakly clean) and clears the decision outputs and the four outcome counts.
- R9: Each training event increments exactly one outcome count, chosen by {`train_pred_dirty`, `train_written`}: 11 → `n_pd_ad`, 01 → `n_pc_ad`, 00 → `n_pc_ac`, 10 → `n_pd_ac`. Each count saturates at all ones.
- R10: When a miss and a training event hit the same index in one cycle, the miss is decided on the counter value from before the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| miss_valid | input | 1 | A cache miss is presented |
| miss_pc | input | PC_W | PC of the instruction causing the miss |
| miss_is_write | input | 1 | 1 for a write miss, 0 for a read miss |
| train_valid | input | 1 | An eviction training event is presented |
| train_pc | input | PC_W | PC that installed the evicted line |
| train_written | input | 1 | The evicted line was written while resident |
| train_pred_dirty | input | 1 | The evicted line had been predicted dirty |
| dec_valid | output | 1 | Decision valid |
| dec_install | output | 1 | Install the line (0 = bypass) |
| dec_dirty | output | 1 | Mark metadata dirty and set the dirtiness bit at install |
| n_pd_ad | output | CNT_W | Predicted dirty, actually dirty |
| n_pc_ad | output | CNT_W | Predicted clean, actually dirty |
| n_pc_ac | output | CNT_W | Predicted clean, actually clean |
| n_pd_ac | output | CNT_W | Predicted dirty, actually clean |

## Verification
The embedded assertions check on every cycle the properties that hold for any input. A decision follows its miss by exactly one cycle. A write miss is never bypassed. A dirty mark never comes without an install. The random register never reaches the all-zero lock state. The outcome counts never decrease.

Only the bench's scenarios can show the rest. These are counter training and saturation, PC aliasing into one entry, and the read-before-update ordering on a same-cycle collision. They also cover the exact bypass pattern chosen by the random sequence and the approximate nine-in-ten bypass rate. A behavioural model tracks all of these each clock.

// File: rtl/write_intent_predictor.sv
module write_intent_predictor #(
  parameter int PC_W      = 32,
  parameter int IDX_W     = 9,
  parameter int CTR_W     = 2,
  parameter int CMP_W     = 10,
  parameter int BYP_LIMIT = 922,
  parameter logic [15:0] RND_SEED = 16'hACE1,
  parameter int CNT_W     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             miss_valid,
  input  logic [PC_W-1:0]  miss_pc,
  input  logic             miss_is_write,
  input  logic             train_valid,
  input  logic [PC_W-1:0]  train_pc,
  input  logic             train_written,
  input  logic             train_pred_dirty,
  output logic             dec_valid,
  output logic             dec_install,
  output logic             dec_dirty,
  output logic [CNT_W-1:0] n_pd_ad,
  output logic [CNT_W-1:0] n_pc_ad,
  output logic [CNT_W-1:0] n_pc_ac,
  output logic [CNT_W-1:0] n_pd_ac
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam logic [CTR_W-1:0] CTR_MAX  = '1;
  localparam logic [CTR_W-1:0] CTR_THR  = CTR_W'(1 << (CTR_W-1));
  localparam logic [CTR_W-1:0] CTR_INIT = CTR_W'((1 << (CTR_W-1)) - 1);
  localparam logic [CMP_W:0]   LIM      = (CMP_W+1)'(BYP_LIMIT);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;

  function automatic logic [IDX_W-1:0] sig(input logic [PC_W-1:0] pc);
    return pc[IDX_W+1:2] ^ pc[2*IDX_W+1:IDX_W+2];
  endfunction

  logic [CTR_W-1:0] tbl [ENTRIES];
  logic [15:0]      rnd;
  logic [CNT_W-1:0] cnt [4];

  wire [IDX_W-1:0] m_idx    = sig(miss_pc);
  wire [IDX_W-1:0] t_idx    = sig(train_pc);
  wire             m_pred   = tbl[m_idx] >= CTR_THR;
  wire             m_bypass = !miss_is_write && !m_pred && ({1'b0, rnd[CMP_W-1:0]} < LIM);
  wire             rnd_fb   = rnd[15] ^ rnd[13] ^ rnd[12] ^ rnd[10];
  wire [1:0]       o_sel    = {train_pred_dirty, train_written};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rnd <= RND_SEED;
    else        rnd <= {rnd[14:0], rnd_fb};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) tbl[i] <= CTR_INIT;
    end else if (train_valid) begin
      if (train_written && tbl[t_idx] != CTR_MAX)  tbl[t_idx] <= tbl[t_idx] + 1'b1;
      else if (!train_written && tbl[t_idx] != '0) tbl[t_idx] <= tbl[t_idx] - 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      dec_valid   <= 1'b0;
      dec_install <= 1'b0;
      dec_dirty   <= 1'b0;
    end else begin
      dec_valid   <= miss_valid;
      dec_install <= miss_valid && !m_bypass;
      dec_dirty   <= miss_valid && (miss_is_write || m_pred);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int k = 0; k < 4; k++) cnt[k] <= '0;
    end else if (train_valid && cnt[o_sel] != CNT_MAX) begin
      cnt[o_sel] <= cnt[o_sel] + 1'b1;
    end

  assign n_pc_ac = cnt[0];
  assign n_pc_ad = cnt[1];
  assign n_pd_ac = cnt[2];
  assign n_pd_ad = cnt[3];

  p_dec_follows_miss_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid == $past(miss_valid));
  p_write_installs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    miss_valid && miss_is_write |=> dec_install && dec_dirty);
  p_dirty_needs_install_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dec_dirty |-> dec_install && dec_valid);
  p_rnd_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rnd != 16'h0000);
  p_counts_monotonic_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ##1 (n_pd_ad >= $past(n_pd_ad)) && (n_pc_ad >= $past(n_pc_ad)) &&
        (n_pc_ac >= $past(n_pc_ac)) && (n_pd_ac >= $past(n_pd_ac)));
  p_single_count_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !train_valid |=> $stable(n_pd_ad) && $stable(n_pc_ad) && $stable(n_pc_ac) && $stable(n_pd_ac));
endmodule

// File: tb/test_write_intent_predictor.sv
module test_write_intent_predictor;
  localparam int CLK_P = 10;
  localparam int CW    = 4;
  localparam int CMAX  = (1 << CW) - 1;

  logic clk = 0, rst_n = 0;
  logic miss_valid = 0, miss_is_write = 0, train_valid = 0, train_written = 0, train_pred_dirty = 0;
  logic [31:0] miss_pc = 0, train_pc = 0;
  logic dec_valid, dec_install, dec_dirty;
  logic [CW-1:0] n_pd_ad, n_pc_ad, n_pc_ac, n_pd_ac;

  write_intent_predictor #(.CNT_W(CW)) i_write_intent_predictor (
    .clk, .rst_n, .miss_valid, .miss_pc, .miss_is_write,
    .train_valid, .train_pc, .train_written, .train_pred_dirty,
    .dec_valid, .dec_install, .dec_dirty, .n_pd_ad, .n_pc_ad, .n_pc_ac, .n_pd_ac);

  always #(CLK_P/2) clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;
  int mc [512];
  int oc [4];
  int lf;
  int e_valid, e_install, e_dirty;
  string e_req = "R8";

  function automatic int idx(input logic [31:0] pc);
    return int'(pc[10:2] ^ pc[19:11]);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 512; i++) mc[i] = 1;
      for (int k = 0; k < 4; k++) oc[k] = 0;
      lf = 16'hACE1;
      e_valid = 0; e_install = 0; e_dirty = 0; e_req = "R8";
    end else begin
      bit pred, byp;
      pred = mc[idx(miss_pc)] >= 2;
      byp  = !miss_is_write && !pred && ((lf & 1023) < 922);
      e_valid   = miss_valid;
      e_install = miss_valid && !byp;
      e_dirty   = miss_valid && (miss_is_write || pred);
      e_req = !miss_valid ? "R2" : miss_is_write ? "R3" : pred ? "R4" : "R5";
      if (train_valid) begin
        int t, o;
        t = idx(train_pc);
        if (train_written && mc[t] < 3) mc[t]++;
        else if (!train_written && mc[t] > 0) mc[t]--;
        o = {train_pred_dirty, train_written};
        if (oc[o] < CMAX) oc[o]++;
      end
      lf = ((lf << 1) & 16'hFFFF) | (((lf >> 15) ^ (lf >> 13) ^ (lf >> 12) ^ (lf >> 10)) & 1);
    end
  end

  always @(negedge clk) begin
    chk(dec_valid == e_valid, {e_req, " valid"}, dec_valid, e_valid);
    chk(dec_install == e_install, {e_req, " install"}, dec_install, e_install);
    chk(dec_dirty == e_dirty, {e_req, " dirty"}, dec_dirty, e_dirty);
    chk(n_pc_ac == oc[0] && n_pc_ad == oc[1] && n_pd_ac == oc[2] && n_pd_ad == oc[3],
        "R9 counts", {n_pd_ad, n_pc_ad, n_pc_ac, n_pd_ac}, {oc[3][3:0], oc[1][3:0], oc[0][3:0], oc[2][3:0]});
  end

  task automatic cyc(input bit mv, input logic [31:0] mpc, input bit mw,
                     input bit tv, input logic [31:0] tpc, input bit tw, input bit tpd);
    @(negedge clk);
    miss_valid = mv; miss_pc = mpc; miss_is_write = mw;
    train_valid = tv; train_pc = tpc; train_written = tw; train_pred_dirty = tpd;
  endtask

  task automatic idle(); cyc(0, 0, 0, 0, 0, 0, 0); endtask
  task automatic rmiss(input logic [31:0] pc); cyc(1, pc, 0, 0, 0, 0, 0); endtask
  task automatic train(input logic [31:0] pc, input bit w, input bit pd); cyc(0, 0, 0, 1, pc, w, pd); endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] pa, pb, pc;
    int byp;
    pa = 32'h0000_1234;
    pb = pa ^ 32'h0000_0804;  // R1 alias: same index as pa
    pc = 32'h0003_3330;
    repeat (3) @(negedge clk);
    chk(!dec_valid && !dec_install && !dec_dirty && n_pd_ad == 0, "R8 reset", dec_valid, 0);
    rst_n = 1;
    // R3 write misses on an untrained PC
    repeat (4) cyc(1, pc, 1, 0, 0, 0, 0);
    idle();
    chk(dec_install && dec_dirty, "R3 write miss", {dec_install, dec_dirty}, 3);
    // R7 R1 training through the alias, then R4 read via the other PC
    train(pa, 1, 0); train(pa, 1, 0); train(pb, 1, 1);
    rmiss(pb); idle();
    chk(dec_install && dec_dirty, "R4 predicted dirty via alias R1", {dec_install, dec_dirty}, 3);
    // R7 decrement back to clean, and saturation at 0
    repeat (5) train(pa, 0, 1);
    repeat (6) rmiss(pa);
    idle();
    chk(!dec_dirty, "R7 decremented to clean", dec_dirty, 0);
    // R10 same-cycle collision: counter at 1, miss sees old value
    train(pc, 1, 0); train(pc, 0, 0); train(pc, 0, 0);
    train(pc, 1, 0);
    cyc(1, pc, 0, 1, pc, 1, 0);
    idle();
    chk(!dec_dirty, "R10 pre-update value", dec_dirty, 0);
    rmiss(pc); idle();
    chk(dec_dirty && dec_install, "R10 updated value", dec_dirty, 1);
    // R5 R6 bypass rate on a fresh clean PC
    byp = 0;
    for (int i = 0; i < 200; i++) begin
      rmiss(32'h0000_0100);
      if (i > 0 && !dec_install) byp++;
    end
    idle();
    if (!dec_install) byp++;
    chk(byp >= 160 && byp <= 195, "R5 bypass rate", byp, 180);
    // R9 outcome-count saturation
    for (int i = 0; i < 20; i++) train(32'h0000_0200, 1, 1);
    idle();
    chk(n_pd_ad == CMAX, "R9 saturate", n_pd_ad, CMAX);
    // random mix
    for (int i = 0; i < 3000; i++)
      cyc($urandom_range(0, 1), $urandom_range(0, 63) << 2, $urandom_range(0, 3) == 0,
          $urandom_range(0, 1), $urandom_range(0, 63) << 2, $urandom_range(0, 1), $urandom_range(0, 1));
    idle(); idle();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule